// File: doc/BRIEF.md
# Multiplexed-Bus Register Interface Controller

This block is the peripheral end of an 8-bit microprocessor bus that carries address and data on the same lines. A falling edge on the address strobe captures two things: a 3-bit register address from the low bus lines, and whether chip select is asserted. That captured select then allows or blocks every read and write until the next address strobe. A read strobe places the addressed register on the bus. The bus is modelled as separate input, output and output-enable signals. A write strobe loads the addressed register when it rises.

The register set has three writable registers and one read-only register:

| Address | Register | Access |
|---|---|---|
| 0 | Control register A | read/write |
| 1 | Control register B | read/write |
| 2 | Detect register | read-only |
| 3 | Tone register | read/write |
| 4 to 7 | none | read as zero, writes ignored |

The detect register collects detect-flag inputs as sticky bits. Any set bit drives the open-drain interrupt low. A completed read of the detect register clears both the register and the interrupt.

One bit of control register B selects what the clock output carries. It picks the 16x baud clock, but only while the phase-shift-keying mode input is high. Otherwise the clock output carries the crystal clock.

All strobes are sampled on the system clock, and their edges are found by comparing each strobe with its value one cycle earlier.

Top module: `mux_bus_reg_if`

## Requirements
- R1: On each falling edge of `ale` (seen as high in one cycle and low in the next), the block stores `adIn[2:0]` as the register address. It also stores chip select as active if `csN` is low and as inactive otherwise.
- R2: While the stored chip select is inactive, `adOe` stays 0 and no register is written.
- R3: `adOe` is 1 only while `rdN` is low and the stored chip select is active. While `adOe` is 1, `adOut` shows the register at the stored address.
- R4: On a rising edge of `wrN` with chip select active, `adIn` is stored into the addressed register. Address 0 is control register A, address 1 is control register B and address 3 is the tone register. The stored value reads back unchanged.
- R5: A write to address 2 leaves the detect register unchanged. Addresses 4 to 7 read as 0x00 and ignore writes.
- R6: A detect-flag input that is high in any cycle sets its bit in the detect register, which reads at address 2 with flag i in bit i. `intOe` is high in the next cycle and stays high until the detect register is cleared.
- R7: A rising edge of `rdN` with chip select active and address 2 clears the detect register. Any flag that is high in that same cycle is kept. A read with chip select inactive clears nothing.
- R8: While `rst` is high, control registers A and B, the tone register and the detect register are set to zero. `intOe` becomes 0 and `clkOut` follows `xtalClk`.
- R9: `clkOut` follows `baudClk16` only when bit 7 of control register B is set and `dpskMode` is high. In every other case it follows `xtalClk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all strobes are sampled |
| rst | input | 1 | Active-high reset |
| ale | input | 1 | Address strobe; its falling edge stores the address and chip select |
| csN | input | 1 | Active-low chip select, stored at the address strobe |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe; data is taken when it rises |
| adIn | input | 8 | Bus value as seen at the pins |
| adOut | output | 8 | Read data that the block drives onto the bus |
| adOe | output | 1 | Bus output enable; when 0 the bus is high impedance |
| detFlags | input | 4 | Detect-flag inputs |
| dpskMode | input | 1 | High when the phase-shift-keying mode is active |
| xtalClk | input | 1 | Crystal clock |
| baudClk16 | input | 1 | Clock at 16 times the data rate |
| clkOut | output | 1 | Selected output clock |
| intOe | output | 1 | Interrupt pull-down enable; 1 drives the open-drain line low |

## Verification
Every one of the eight addresses is written with two complementary data patterns, once with chip select active and once with it inactive. All addresses are then read back. This shows whether each register is decoded at its own address, whether address 2 and addresses 4 to 7 resist writes, and whether the stored chip select really blocks writes.

Each detect flag is pulsed on its own, and then several flags are pulsed together. This tells apart sticky capture, the correct bit position and clearing by the read.

A flag that arrives in the same cycle as the end of a read checks that the flag survives the clear. A read made with chip select inactive checks that such a read neither drives the bus nor clears the detect register.

All four combinations of the clock-select bit and the mode input, together with a reset in the middle of the run, separate the clock-output rule from the reset defaults.

// File: rtl/mux_bus_reg_pkg.sv
package mux_bus_reg_pkg;
  localparam int ADDR_W = 3;

  // Decoded register addresses
  localparam logic [ADDR_W-1:0] ADDR_CTRLA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRLB = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DET   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TONE  = 3'd3;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic              wrEn;   // write the addressed register this cycle
    logic              detClr; // detect read has completed
    logic              csOk;   // chip select stored as active
    logic [ADDR_W-1:0] addr;   // stored register address
  } ctl_strb_t;
endpackage

// File: rtl/mux_bus_reg_ctrl.sv
module mux_bus_reg_ctrl
  import mux_bus_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] adLow,
  output ctl_strb_t         strb,
  output logic              busOe
);
  logic aleQ, rdQ, wrQ, csOk;
  logic [ADDR_W-1:0] addrQ;

  // R1: store the address and chip select on the falling edge of the address strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      aleQ  <= 1'b0;
      rdQ   <= 1'b1;
      wrQ   <= 1'b1;
      csOk  <= 1'b0;
      addrQ <= '0;
    end else begin
      aleQ <= ale;
      rdQ  <= rdN;
      wrQ  <= wrN;
      if (aleQ && !ale) begin
        addrQ <= adLow;
        csOk  <= !csN;
      end
    end
  end

  always_comb begin
    strb.addr   = addrQ;
    strb.csOk   = csOk;
    // R4: a write takes effect when the write strobe rises
    strb.wrEn   = !wrQ && wrN && csOk;
    // R7: a read of the detect register completes when the read strobe rises
    strb.detClr = !rdQ && rdN && csOk && (addrQ == ADDR_DET);
    // R2, R3: drive the bus only during a read with chip select active
    busOe       = !rdN && csOk;
  end
endmodule

// File: rtl/mux_bus_reg_dp.sv
module mux_bus_reg_dp
  import mux_bus_reg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DET_W      = 4,
  parameter int CLKSEL_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_strb_t         strb,
  input  logic [DATA_W-1:0] adIn,
  input  logic [DET_W-1:0]  detFlags,
  input  logic              dpskMode,
  input  logic              xtalClk,
  input  logic              baudClk16,
  output logic [DATA_W-1:0] adOut,
  output logic              intOe,
  output logic              clkOut,
  output logic [DATA_W-1:0] ctrlAVal,
  output logic [DATA_W-1:0] ctrlBVal,
  output logic [DATA_W-1:0] toneVal,
  output logic [DET_W-1:0]  detVal
);
  logic [DATA_W-1:0] ctrlA, ctrlB, tone;
  logic [DET_W-1:0]  det;

  // R4, R5, R8: the writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlA <= '0;
      ctrlB <= '0;
      tone  <= '0;
    end else if (strb.wrEn) begin
      case (strb.addr)
        ADDR_CTRLA: ctrlA <= adIn;
        ADDR_CTRLB: ctrlB <= adIn;
        ADDR_TONE:  tone  <= adIn;
        default: ;
      endcase
    end
  end

  // R6, R7: sticky detect bits; a flag that is high in the clear cycle is kept
  always_ff @(posedge clk) begin
    if (rst)              det <= '0;
    else if (strb.detClr) det <= detFlags;
    else                  det <= det | detFlags;
  end

  always_comb begin
    adOut = '0;
    case (strb.addr)
      ADDR_CTRLA: adOut = ctrlA;
      ADDR_CTRLB: adOut = ctrlB;
      ADDR_DET:   adOut[DET_W-1:0] = det;
      ADDR_TONE:  adOut = tone;
      default:    adOut = '0;
    endcase
  end

  assign intOe    = |det;
  // R9: the baud clock is used only when selected and the mode input is high
  assign clkOut   = (ctrlB[CLKSEL_BIT] && dpskMode) ? baudClk16 : xtalClk;
  assign ctrlAVal = ctrlA;
  assign ctrlBVal = ctrlB;
  assign toneVal  = tone;
  assign detVal   = det;
endmodule

// File: rtl/mux_bus_reg_if.sv
module mux_bus_reg_if
  import mux_bus_reg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DET_W      = 4,
  parameter int CLKSEL_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  input  logic [DET_W-1:0]  detFlags,
  input  logic              dpskMode,
  input  logic              xtalClk,
  input  logic              baudClk16,
  output logic              clkOut,
  output logic              intOe
);
  ctl_strb_t         strb;
  logic [DATA_W-1:0] ctrlAVal, ctrlBVal, toneVal;
  logic [DET_W-1:0]  detVal;

  mux_bus_reg_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .ale   (ale),
    .csN   (csN),
    .rdN   (rdN),
    .wrN   (wrN),
    .adLow (adIn[ADDR_W-1:0]),
    .strb  (strb),
    .busOe (adOe)
  );

  mux_bus_reg_dp #(
    .DATA_W     (DATA_W),
    .DET_W      (DET_W),
    .CLKSEL_BIT (CLKSEL_BIT)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .adIn      (adIn),
    .detFlags  (detFlags),
    .dpskMode  (dpskMode),
    .xtalClk   (xtalClk),
    .baudClk16 (baudClk16),
    .adOut     (adOut),
    .intOe     (intOe),
    .clkOut    (clkOut),
    .ctrlAVal  (ctrlAVal),
    .ctrlBVal  (ctrlBVal),
    .toneVal   (toneVal),
    .detVal    (detVal)
  );
endmodule

// File: rtl/mux_bus_reg_chk.sv
module mux_bus_reg_chk
  import mux_bus_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DET_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rdN,
  input logic              adOe,
  input logic              intOe,
  input logic [DATA_W-1:0] adIn,
  input logic [DET_W-1:0]  detFlags,
  input logic              wrEn,
  input logic              detClr,
  input logic              csOk,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] ctrlAVal,
  input logic [DATA_W-1:0] ctrlBVal,
  input logic [DATA_W-1:0] toneVal
);
  a_r2_no_write_cs_off: assert property (@(posedge clk) disable iff (rst)
    (!csOk && !rst) |=> ($stable(ctrlAVal) && $stable(ctrlBVal) && $stable(toneVal)));

  a_r2_no_drive_cs_off: assert property (@(posedge clk) disable iff (rst)
    !csOk |-> !adOe);

  a_r3_no_drive_without_read: assert property (@(posedge clk) disable iff (rst)
    rdN |-> !adOe);

  a_r4_ctrla_write: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_CTRLA) |=> (ctrlAVal == $past(adIn)));

  a_r4_tone_write: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_TONE) |=> (toneVal == $past(adIn)));

  a_r6_flag_raises_int: assert property (@(posedge clk) disable iff (rst)
    (|detFlags) |=> intOe);

  a_r6_int_holds: assert property (@(posedge clk) disable iff (rst)
    (intOe && !detClr) |=> intOe);

  a_r7_clear_drops_int: assert property (@(posedge clk) disable iff (rst)
    (detClr && detFlags == '0) |=> !intOe);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!intOe && ctrlAVal == '0 && ctrlBVal == '0 && toneVal == '0));
endmodule

bind mux_bus_reg_if mux_bus_reg_chk #(.DATA_W(DATA_W), .DET_W(DET_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rdN      (rdN),
  .adOe     (adOe),
  .intOe    (intOe),
  .adIn     (adIn),
  .detFlags (detFlags),
  .wrEn     (strb.wrEn),
  .detClr   (strb.detClr),
  .csOk     (strb.csOk),
  .addr     (strb.addr),
  .ctrlAVal (ctrlAVal),
  .ctrlBVal (ctrlBVal),
  .toneVal  (toneVal)
);

// File: tb/mux_bus_reg_if_tb.sv
`timescale 1ns/1ps
module mux_bus_reg_if_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] adIn = 8'h00;
  logic [7:0] adOut;
  logic       adOe;
  logic [3:0] detFlags = 4'h0;
  logic       dpskMode = 1'b0, xtalClk = 1'b1, baudClk16 = 1'b0;
  logic       clkOut, intOe;

  int checks = 0;
  int failures = 0;
  logic [7:0] expReg [8];

  always #2.5 clk = ~clk;

  mux_bus_reg_if u_dut (
    .clk(clk), .rst(rst), .ale(ale), .csN(csN), .rdN(rdN), .wrN(wrN),
    .adIn(adIn), .adOut(adOut), .adOe(adOe), .detFlags(detFlags),
    .dpskMode(dpskMode), .xtalClk(xtalClk), .baudClk16(baudClk16),
    .clkOut(clkOut), .intOe(intOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic latchAddr(input logic [2:0] a, input bit csAct);
    @(negedge clk); ale = 1'b1; adIn = {5'b0, a}; csN = !csAct;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); csN = 1'b1; adIn = 8'h00;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d, input bit csAct);
    latchAddr(a, csAct);
    adIn = d; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); adIn = 8'h00;
  endtask

  task automatic busRead(input logic [2:0] a, input bit csAct,
                         output logic [7:0] d, output logic oe);
    latchAddr(a, csAct);
    rdN = 1'b0; #1;
    d = adOut; oe = adOe;
    @(negedge clk); rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseFlags(input logic [3:0] f);
    @(negedge clk); detFlags = f;
    @(negedge clk); detFlags = 4'h0;
  endtask

  initial begin
    for (int i = 0; i < 40000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    for (int i = 0; i < 8; i++) expReg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: values after reset
    check("R8 int after reset", {7'b0, intOe}, 8'h00);
    check("R8 clkOut after reset", {7'b0, clkOut}, {7'b0, xtalClk});
    check("R3 oe idle", {7'b0, adOe}, 8'h00);

    // R1, R2, R4, R5: write sweep over every address, both chip-select levels
    for (int p = 0; p < 2; p++) begin
      for (int cs = 0; cs < 2; cs++) begin
        for (int a = 0; a < 8; a++) begin
          logic [7:0] dv;
          dv = (8'(a) * 8'd29 + 8'h5A) ^ (p != 0 ? 8'hFF : 8'h00);
          busWrite(3'(a), dv, cs != 0);
          if (cs != 0 && (a == 0 || a == 1 || a == 3)) expReg[a] = dv;
        end
        for (int a = 0; a < 8; a++) begin
          busRead(3'(a), 1'b1, d, oe);
          check("R3 oe on read", {7'b0, oe}, 8'h01);
          check("R1 R4 R5 readback", d, expReg[a]);
        end
        busRead(3'd0, 1'b0, d, oe);
        check("R2 no drive when cs inactive", {7'b0, oe}, 8'h00);
      end
    end

    // R6, R7: each flag on its own
    for (int i = 0; i < 4; i++) begin
      pulseFlags(4'(1 << i));
      #1;
      check("R6 int raised", {7'b0, intOe}, 8'h01);
      busRead(3'd2, 1'b1, d, oe);
      check("R6 detect bit", d, 8'(1 << i));
      #1;
      check("R7 int cleared", {7'b0, intOe}, 8'h00);
    end

    // R6: several flags at different times are all kept
    pulseFlags(4'h1);
    repeat (3) @(negedge clk);
    pulseFlags(4'h4);
    #1;
    check("R6 int held", {7'b0, intOe}, 8'h01);
    // R5: a write to address 2 changes nothing
    busWrite(3'd2, 8'hFF, 1'b1);
    // R7: a read with cs inactive clears nothing
    busRead(3'd2, 1'b0, d, oe);
    check("R7 cs-off read no drive", {7'b0, oe}, 8'h00);
    check("R7 cs-off read keeps int", {7'b0, intOe}, 8'h01);
    busRead(3'd2, 1'b1, d, oe);
    check("R5 R6 sticky detect", d, 8'h05);

    // R7: a flag in the clear cycle survives
    pulseFlags(4'h8);
    latchAddr(3'd2, 1'b1);
    rdN = 1'b0; #1;
    check("R7 read before clear", adOut, 8'h08);
    @(negedge clk); rdN = 1'b1; detFlags = 4'h2;
    @(negedge clk); detFlags = 4'h0; #1;
    check("R7 int kept for new flag", {7'b0, intOe}, 8'h01);
    busRead(3'd2, 1'b1, d, oe);
    check("R7 new flag kept", d, 8'h02);

    // R9: all four combinations of select bit and mode input
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        busWrite(3'd1, (s != 0) ? 8'h80 : 8'h7F, 1'b1);
        dpskMode = (m != 0);
        for (int x = 0; x < 2; x++) begin
          xtalClk = (x != 0); baudClk16 = (x == 0);
          #1;
          check("R9 clkOut", {7'b0, clkOut},
                {7'b0, (s != 0 && m != 0) ? baudClk16 : xtalClk});
        end
      end
    end

    // R8: reset in the middle of the run
    busWrite(3'd0, 8'hC3, 1'b1);
    busWrite(3'd3, 8'h3C, 1'b1);
    pulseFlags(4'hF);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; #1;
    check("R8 int cleared by reset", {7'b0, intOe}, 8'h00);
    check("R8 clkOut to crystal", {7'b0, clkOut}, {7'b0, xtalClk});
    for (int a = 0; a < 4; a++) begin
      busRead(3'(a), 1'b1, d, oe);
      check("R8 register cleared", d, 8'h00);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule